// File: doc/BRIEF.md
# Thread Run-Enable Control Register

This block holds the run-enable mask of a multithreaded processor, one bit per hardware thread, and tells each thread whether it should be parked. Software reaches the mask through a small register bus that has an address, a write enable with 64-bit write data, and a read enable with read data. The same mask can be reached at three offsets. One offset replaces the whole mask. One sets only the bits written as one. One clears only the bits written as one. A fourth offset is a read-only status view that shows which threads are really running.

Each thread gets a park request that is the inverse of its mask bit. The thread answers with a one-cycle acknowledgement once it has actually halted or resumed. The status bit of a thread moves only on that answer, so the status lags the mask. Software polls the status view until it equals the mask. Each thread is tracked by a four-state machine with these states:
- TS_RUNNING: running, no request pending.
- TS_STOPPING: park requested, not yet acknowledged.
- TS_PARKED: halted, no request pending.
- TS_STARTING: resume requested, not yet acknowledged.

The transitions of the machine are:
- RUNNING→STOPPING when the mask bit drops.
- STOPPING→PARKED on a halt acknowledgement.
- STOPPING→RUNNING when the mask bit returns before any acknowledgement (withdraw).
- PARKED→STARTING when the mask bit rises.
- STARTING→RUNNING on a resume acknowledgement.
- STARTING→PARKED when the mask bit falls again before any acknowledgement.

Top module: `thr_run_ctrl`

## Requirements
- R1: After reset the mask and the status are all ones, every park request is low, and a read of any mask view returns all ones.
- R2: A write to byte offset 0x10 clears exactly the mask bits where the write data is 1 and leaves every other bit unchanged. The park request of thread n equals the inverse of mask bit n, from the cycle after the write.
- R3: A write to byte offset 0x08 sets exactly the mask bits where the write data is 1 and leaves every other bit unchanged.
- R4: A write to byte offset 0x00 replaces the whole mask. Reads of offsets 0x00, 0x08 and 0x10 all return the mask. The mask changes only on a write.
- R5: Offset 0x18 reads the status, with bit n meaning thread n is running. Writes to 0x18 change neither the mask nor the status.
- R6: A status bit falls only on a halt acknowledgement for that thread while its park is pending. It rises only on a resume acknowledgement while its resume is pending. Without the matching acknowledgement it keeps its old value for any number of cycles, and an acknowledgement of the wrong kind is ignored.
- R7: If a park request is withdrawn before it is acknowledged, the thread returns to TS_RUNNING. A later stray halt acknowledgement then leaves its status at 1.
- R8: If a halt acknowledgement and a set write for the same thread arrive in the same cycle, the status takes the acknowledgement (bit goes to 0) and the mask takes the write (bit goes to 1). The thread then waits in TS_STARTING for its resume acknowledgement.
- R9: Read data is valid in the cycle after the read enable. Any address other than 0x00, 0x08, 0x10 and 0x18 reads as zero, and writes to such an address are ignored.
- R10: Starting from all threads running, clearing bits 1 to 63 with one write each leads, once all acknowledgements are in, to a status of 0x1 with the mask read equal to the status. Setting bits 1 to 63 again leads to a status of all ones, again equal to the mask read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd_en |
| thr_park_req | output | NUM_THR | Park request per thread (inverse of mask) |
| thr_halt_ack | input | NUM_THR | Per-thread pulse: thread has halted |
| thr_resume_ack | input | NUM_THR | Per-thread pulse: thread has resumed |

## Verification
The bench builds the block with its defaults: NUM_THR=64, DATA_W=64 and ADDR_W=8. With these values the top thread bit 63 and the full park-all-but-thread-zero sequence are reachable, and every offset decode, including unmapped addresses, falls inside the 8-bit address space. A bench-side thread model acknowledges after a programmable delay, which exercises the status lag. Manual acknowledgement pulses reach the withdraw case and the case where a write and an acknowledgement land in the same cycle.

// File: rtl/thr_run_pkg.sv
package thr_run_pkg;

    // Byte offsets of the four register views.
    localparam int unsigned OFS_RUN_RW   = 32'h00;
    localparam int unsigned OFS_RUN_SET  = 32'h08;
    localparam int unsigned OFS_RUN_CLR  = 32'h10;
    localparam int unsigned OFS_RUN_STAT = 32'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RW,
        SEL_SET,
        SEL_CLR,
        SEL_STAT
    } reg_sel_e;

    typedef enum logic [1:0] {
        TS_RUNNING,
        TS_STOPPING,
        TS_PARKED,
        TS_STARTING
    } thr_st_e;

endpackage

// File: rtl/thr_run_dec.sv
module thr_run_dec
    import thr_run_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_RW   = ADDR_W'(OFS_RUN_RW);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_RUN_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_RUN_CLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_RUN_STAT);

    always_comb begin
        if (addr == A_RW)        sel = SEL_RW;
        else if (addr == A_SET)  sel = SEL_SET;
        else if (addr == A_CLR)  sel = SEL_CLR;
        else if (addr == A_STAT) sel = SEL_STAT;
        else                     sel = SEL_NONE;
    end

endmodule

// File: rtl/thr_run_mask.sv
module thr_run_mask
    import thr_run_pkg::*;
#(
    parameter int unsigned NUM_THR = 64,
    parameter int unsigned DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_THR-1:0] mask_q
);

    logic [NUM_THR-1:0] wd;
    logic [NUM_THR-1:0] mask_d;

    assign wd = wdata[NUM_THR-1:0];

    always_comb begin
        mask_d = mask_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_RW:  mask_d = wd;
                SEL_SET: mask_d = mask_q | wd;
                SEL_CLR: mask_d = mask_q & ~wd;
                default: mask_d = mask_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

endmodule

// File: rtl/thr_run_track.sv
module thr_run_track
    import thr_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_run,
    input  logic halt_ack,
    input  logic resume_ack,
    output logic is_running
);

    thr_st_e st_q;
    thr_st_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TS_RUNNING;
        else        st_q <= st_d;
    end

    // Next state: an acknowledgement wins over a reversed request
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_RUNNING:  if (!want_run) st_d = TS_STOPPING;
            TS_STOPPING: begin
                if (halt_ack)      st_d = TS_PARKED;
                else if (want_run) st_d = TS_RUNNING;
            end
            TS_PARKED:   if (want_run) st_d = TS_STARTING;
            TS_STARTING: begin
                if (resume_ack)     st_d = TS_RUNNING;
                else if (!want_run) st_d = TS_PARKED;
            end
            default:     st_d = TS_RUNNING;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            TS_RUNNING, TS_STOPPING: is_running = 1'b1;
            default:                 is_running = 1'b0;
        endcase
    end

endmodule

// File: rtl/thr_run_rdmux.sv
module thr_run_rdmux
    import thr_run_pkg::*;
#(
    parameter int unsigned NUM_THR = 64,
    parameter int unsigned DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  reg_sel_e           rd_sel,
    input  logic [NUM_THR-1:0] mask,
    input  logic [NUM_THR-1:0] status,
    output logic [DATA_W-1:0]  rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (rd_sel)
                SEL_RW, SEL_SET, SEL_CLR: rdata <= DATA_W'(mask);
                SEL_STAT:                 rdata <= DATA_W'(status);
                default:                  rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/thr_run_ctrl.sv
module thr_run_ctrl
    import thr_run_pkg::*;
#(
    parameter int unsigned NUM_THR = 64,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_rd_en,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_THR-1:0] thr_park_req,
    input  logic [NUM_THR-1:0] thr_halt_ack,
    input  logic [NUM_THR-1:0] thr_resume_ack
);

    reg_sel_e           sel;
    logic [NUM_THR-1:0] run_mask;
    logic [NUM_THR-1:0] run_status;

    thr_run_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    thr_run_mask #(.NUM_THR(NUM_THR), .DATA_W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_sel (sel),
        .wdata  (reg_wdata),
        .mask_q (run_mask)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        thr_run_track u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .want_run   (run_mask[t]),
            .halt_ack   (thr_halt_ack[t]),
            .resume_ack (thr_resume_ack[t]),
            .is_running (run_status[t])
        );
    end

    thr_run_rdmux #(.NUM_THR(NUM_THR), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (reg_rd_en),
        .rd_sel (sel),
        .mask   (run_mask),
        .status (run_status),
        .rdata  (reg_rdata)
    );

    assign thr_park_req = ~run_mask;

endmodule

// File: rtl/thr_run_ctrl_chk.sv
module thr_run_ctrl_chk
    import thr_run_pkg::*;
#(
    parameter int unsigned NUM_THR = 64,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr_en,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               reg_rd_en,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [NUM_THR-1:0] thr_park_req,
    input logic [NUM_THR-1:0] thr_halt_ack,
    input logic [NUM_THR-1:0] thr_resume_ack,
    input logic [NUM_THR-1:0] run_status
);

    logic [NUM_THR-1:0] wd;
    logic               unmapped;
    assign wd = reg_wdata[NUM_THR-1:0];
    assign unmapped = (reg_addr != ADDR_W'(OFS_RUN_RW))  && (reg_addr != ADDR_W'(OFS_RUN_SET)) &&
                      (reg_addr != ADDR_W'(OFS_RUN_CLR)) && (reg_addr != ADDR_W'(OFS_RUN_STAT));

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == ADDR_W'(OFS_RUN_CLR) |=>
        ((thr_park_req & $past(wd)) == $past(wd)) &&
        ((thr_park_req & ~$past(wd)) == ($past(thr_park_req) & ~$past(wd)))); // R2

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == ADDR_W'(OFS_RUN_SET) |=>
        ((~thr_park_req & $past(wd)) == $past(wd)) &&
        ((~thr_park_req & ~$past(wd)) == (~$past(thr_park_req) & ~$past(wd)))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> $stable(thr_park_req)); // R4

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == ADDR_W'(OFS_RUN_STAT) |=> $stable(thr_park_req)); // R5

    AST_FALL_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(run_status) & ~run_status & ~$past(thr_halt_ack)) == '0)); // R6

    AST_FALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(run_status) & ~run_status & ~$past(thr_park_req)) == '0)); // R6

    AST_RISE_NEEDS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(run_status) & run_status & ~$past(thr_resume_ack)) == '0)); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en && unmapped |=> reg_rdata == '0); // R9

endmodule

bind thr_run_ctrl thr_run_ctrl_chk #(
    .NUM_THR (NUM_THR),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr_en      (reg_wr_en),
    .reg_wdata      (reg_wdata),
    .reg_rd_en      (reg_rd_en),
    .reg_rdata      (reg_rdata),
    .thr_park_req   (thr_park_req),
    .thr_halt_ack   (thr_halt_ack),
    .thr_resume_ack (thr_resume_ack),
    .run_status     (run_status)
);

// File: tb/thr_run_ctrl_tb_top.sv
module thr_run_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 64;
    localparam int DW = 64;
    localparam int AW = 8;

    localparam logic [AW-1:0] AD_RW   = 8'h00;
    localparam logic [AW-1:0] AD_SET  = 8'h08;
    localparam logic [AW-1:0] AD_CLR  = 8'h10;
    localparam logic [AW-1:0] AD_STAT = 8'h18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_rd_en = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic [NT-1:0] thr_park_req;
    logic [NT-1:0] thr_halt_ack;
    logic [NT-1:0] thr_resume_ack;

    logic [NT-1:0] man_halt = '0;
    logic [NT-1:0] man_resume = '0;
    logic [NT-1:0] auto_halt;
    logic [NT-1:0] auto_resume;
    logic [NT-1:0] model_stopped;
    logic          auto_on = 1'b0;
    int            ack_dly = 3;
    int            cnt [NT];

    int n_checks = 0;
    int n_errors = 0;

    assign thr_halt_ack   = man_halt | auto_halt;
    assign thr_resume_ack = man_resume | auto_resume;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_run_ctrl #(.NUM_THR(NT), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_addr       (reg_addr),
        .reg_wr_en      (reg_wr_en),
        .reg_wdata      (reg_wdata),
        .reg_rd_en      (reg_rd_en),
        .reg_rdata      (reg_rdata),
        .thr_park_req   (thr_park_req),
        .thr_halt_ack   (thr_halt_ack),
        .thr_resume_ack (thr_resume_ack)
    );

    // Thread model: acknowledges a changed request after ack_dly cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_halt     <= '0;
            auto_resume   <= '0;
            model_stopped <= '0;
            for (int n = 0; n < NT; n++) cnt[n] = 0;
        end else begin
            auto_halt   <= '0;
            auto_resume <= '0;
            if (auto_on) begin
                for (int n = 0; n < NT; n++) begin
                    if (thr_park_req[n] != model_stopped[n]) begin
                        if (cnt[n] >= ack_dly) begin
                            cnt[n] = 0;
                            model_stopped[n] <= thr_park_req[n];
                            if (thr_park_req[n]) auto_halt[n]   <= 1'b1;
                            else                 auto_resume[n] <= 1'b1;
                        end else begin
                            cnt[n] = cnt[n] + 1;
                        end
                    end else begin
                        cnt[n] = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; auto_on = 1'b0; man_halt = '0; man_resume = '0;
        reg_wr_en = 1'b0; reg_rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_ack(input logic [NT-1:0] h, input logic [NT-1:0] r);
        @(negedge clk);
        man_halt = h; man_resume = r;
        @(negedge clk);
        man_halt = '0; man_resume = '0;
    endtask

    task automatic poll_status(input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] v;
        v = '0;
        for (int i = 0; i < 300; i++) begin
            rd(AD_STAT, v);
            if (v == exp) break;
        end
        check(req, v, exp);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        do_reset();
        check("R1 park_req", thr_park_req, '0);
        rd(AD_RW, v);   check("R1 mask", v, '1);
        rd(AD_STAT, v); check("R1 status", v, '1);
    endtask

    task automatic t_set_clear();
        logic [DW-1:0] v;
        logic [DW-1:0] a;
        do_reset();
        a = 64'h80FF_0000_0000_F00F;
        wr(AD_CLR, a);
        check("R2 park_req after clear", thr_park_req, a);
        rd(AD_RW, v);  check("R2 mask after clear", v, ~a);
        rd(AD_SET, v); check("R4 set alias reads mask", v, ~a);
        wr(AD_SET, 64'h8000_0000_0000_F000);
        rd(AD_CLR, v); check("R3 mask after set", v, ~64'h00FF_0000_0000_000F);
    endtask

    task automatic t_rw_write();
        logic [DW-1:0] v;
        do_reset();
        wr(AD_RW, 64'h1234_5678_9ABC_DEF0);
        rd(AD_RW, v); check("R4 whole replace", v, 64'h1234_5678_9ABC_DEF0);
        check("R4 park_req", thr_park_req, ~64'h1234_5678_9ABC_DEF0);
        wr(AD_STAT, '0);
        rd(AD_RW, v);   check("R5 status write leaves mask", v, 64'h1234_5678_9ABC_DEF0);
        rd(AD_STAT, v); check("R5 status write leaves status", v, '1);
        wr(8'h20, '0);
        rd(AD_RW, v);   check("R9 unmapped write ignored", v, 64'h1234_5678_9ABC_DEF0);
        rd(8'h20, v);   check("R9 unmapped read 0x20", v, '0);
        rd(8'h04, v);   check("R9 unmapped read 0x04", v, '0);
    endtask

    task automatic t_lag();
        logic [DW-1:0] v;
        do_reset();
        wr(AD_CLR, 64'h8);
        repeat (20) @(negedge clk);
        rd(AD_STAT, v); check("R6 status lags without ack", v, '1);
        pulse_ack('0, 64'h8);
        rd(AD_STAT, v); check("R6 wrong ack ignored", v, '1);
        pulse_ack(64'h8, '0);
        rd(AD_STAT, v); check("R6 halt ack clears status", v, ~64'h8);
        wr(AD_SET, 64'h8);
        repeat (10) @(negedge clk);
        rd(AD_STAT, v); check("R6 status lags resume", v, ~64'h8);
        pulse_ack('0, 64'h8);
        rd(AD_STAT, v); check("R6 resume ack sets status", v, '1);
    endtask

    task automatic t_withdraw();
        logic [DW-1:0] v;
        do_reset();
        wr(AD_CLR, 64'h80);
        wr(AD_SET, 64'h80);
        repeat (2) @(negedge clk);
        pulse_ack(64'h80, '0);
        rd(AD_STAT, v); check("R7 withdrawn park keeps running", v, '1);
        rd(AD_RW, v);   check("R7 mask after withdraw", v, '1);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        do_reset();
        wr(AD_CLR, 64'h20);
        @(negedge clk);
        reg_addr = AD_SET; reg_wdata = 64'h20; reg_wr_en = 1'b1; man_halt = 64'h20;
        @(negedge clk);
        reg_wr_en = 1'b0; man_halt = '0;
        rd(AD_STAT, v); check("R8 status took ack", v, ~64'h20);
        rd(AD_RW, v);   check("R8 mask took write", v, '1);
        pulse_ack('0, 64'h20);
        rd(AD_STAT, v); check("R8 resume completes", v, '1);
    endtask

    task automatic t_sequence(input int dly);
        logic [DW-1:0] v;
        logic [DW-1:0] s;
        do_reset();
        ack_dly = dly;
        auto_on = 1'b1;
        for (int k = 1; k < NT; k++) wr(AD_CLR, 64'h1 << k);
        poll_status(64'h1, "R10 park all but thread 0");
        rd(AD_STAT, s); rd(AD_RW, v);
        check("R10 mask equals status after park", v, s);
        for (int k = 1; k < NT; k++) wr(AD_SET, 64'h1 << k);
        poll_status('1, "R10 unpark all");
        rd(AD_STAT, s); rd(AD_RW, v);
        check("R10 mask equals status after unpark", v, s);
        auto_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_set_clear();
        t_rw_write();
        t_lag();
        t_withdraw();
        t_collide();
        t_sequence(0);
        t_sequence(3);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule